// File: doc/BRIEF.md
# Auto-Increment Lookup SRAM Loader

This block lets software fill and inspect an external lookup SRAM through a narrow 16-bit register bus. Software first sets the upper address bits, then writes the lower 16 address bits, which loads a full address counter. After that every access to a data register performs one SRAM cycle at the counter value and then moves the counter forward by one. Long tables can therefore be streamed in or out without rewriting the address.

The SRAM is twice the bus width. Software sees it as two 16-bit memories, a low half and a high half, that share one address counter. A data write to one half pulses only that half's write enable. A data read returns the selected half after a fixed latency. All SRAM control strobes are active low. While an access is in progress the block reports `busy` and ignores any other bus request.

Top module: `sram_loader_port`

## Requirements
- R1: After reset, `sram_ce_n`, `sram_oe_n`, `sram_we_lo_n` and `sram_we_hi_n` are high, `busy` and `reg_rvalid` are low, and `sram_addr` is zero.
- R2: `reg_sel` selects the target: 0 is the upper address register (takes `reg_wdata[ADDR_W-17:0]`), 1 is the lower address register, 2 is the low data half (SRAM bits 15:0), 3 is the high data half (SRAM bits 31:16).
- R3: Each accepted data read or data write advances `sram_addr` by one once its SRAM cycle ends, and the address wraps from all ones to zero.
- R4: An accepted data write (request in cycle 0) holds `sram_ce_n` low in cycles 1 to 3 and pulls the write enable of the selected half, and only that one, low for exactly cycle 2; the written word appears on the matching 16 bits of `sram_wdata`.
- R5: `sram_addr` and `sram_wdata` are unchanged in the cycle before, during and after a write strobe.
- R6: An accepted data read (request in cycle 0) holds `sram_ce_n` and `sram_oe_n` low in cycles 1 and 2 and raises `reg_rvalid` for one cycle in cycle 3 with the selected half of the SRAM word on `reg_rdata`.
- R7: `sram_oe_n` is never low while any write enable is low.
- R8: Any register write or read issued while `busy` is high has no effect: no extra SRAM cycle, no address change.
- R9: Writing the upper address register alone does not change `sram_addr`; the counter is loaded from both address registers only when the lower one is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request (data registers only) |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | One-cycle read data valid |
| busy | output | 1 | SRAM access in progress, requests ignored |
| sram_addr | output | ADDR_W | SRAM address (counter value) |
| sram_wdata | output | 32 | Data driven to the SRAM |
| sram_wdata_oe | output | 1 | Enables the SRAM data drivers during a write |
| sram_rdata | input | 32 | Data returned by the SRAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_lo_n | output | 1 | Low-half write enable, active low |
| sram_we_hi_n | output | 1 | High-half write enable, active low |

## Verification
A counter that fails to advance or loads the wrong halves shows on `sram_addr` right after the next data access, and the bench compares that port with its own address model after every operation. A sequencer stuck or skipping a state shows as a strobe that is too long, missing or in the wrong cycle, which the bench samples in cycles 1 to 3 of every access. A wrong lane register shows as the other half's write enable pulsing or the other half returned, caught when the scoreboard compares read-back words within three cycles of each read.

// File: rtl/sram_loader_pkg.sv
// Shared types for the SRAM loader port.
// Assumes a two-bit register select where bit 1 marks a data register
// and bit 0 picks the data half (or the address half).
package sram_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WSTROBE = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RADDR   = 3'd4,
        ST_RSAMPLE = 3'd5
    } ld_state_t;

    typedef enum logic [1:0] {
        SEL_ADDR_HI = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_DATA_LO = 2'd2,
        SEL_DATA_HI = 2'd3
    } ld_sel_t;

endpackage

// File: rtl/loader_addr_ctr.sv
// Address register pair and auto-increment counter.
// Assumes ADDR_W > WORD_W. The upper part is held until the lower part
// is written; only then is the whole counter loaded.
module loader_addr_ctr #(
    parameter int ADDR_W = 19,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_load,
    input  logic              lo_load,
    input  logic              advance,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - WORD_W;

    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] cnt_q;

    // Hold the upper address bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_q <= '0;
        else if (hi_load) hi_q <= wdata[HI_W-1:0];
    end

    // Load the counter on a lower-address write, else step it after an access.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (lo_load) cnt_q <= {hi_q, wdata};
        else if (advance) cnt_q <= cnt_q + ADDR_W'(1);
    end

    assign addr = cnt_q;

    // R9: an upper-address write alone leaves the counter where it was.
    a_r9_hi_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_load && !lo_load && !advance) |=> $stable(addr));

endmodule

// File: rtl/loader_seq.sv
// Access sequencer: runs one SRAM write (setup, strobe, hold) or one
// SRAM read (address, sample) per accepted request. Strobes are
// registered from the next state so they leave the block glitch free.
// Assumes start_wr and start_rd are only raised while idle.
module loader_seq
    import sram_loader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_rd,
    output logic busy,
    output logic ce_n,
    output logic oe_n,
    output logic we_pulse,
    output logic wr_active,
    output logic advance,
    output logic capture
);
    ld_state_t state_q, state_nxt;

    // Next-state choice for the access sequence.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)      state_nxt = ST_WSETUP;
                else if (start_rd) state_nxt = ST_RADDR;
            end
            ST_WSETUP:  state_nxt = ST_WSTROBE;
            ST_WSTROBE: state_nxt = ST_WHOLD;
            ST_WHOLD:   state_nxt = ST_IDLE;
            ST_RADDR:   state_nxt = ST_RSAMPLE;
            ST_RSAMPLE: state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Registered SRAM strobes decoded from the coming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n      <= 1'b1;
            oe_n      <= 1'b1;
            we_pulse  <= 1'b0;
            wr_active <= 1'b0;
        end else begin
            ce_n      <= (state_nxt == ST_IDLE);
            oe_n      <= !((state_nxt == ST_RADDR) || (state_nxt == ST_RSAMPLE));
            we_pulse  <= (state_nxt == ST_WSTROBE);
            wr_active <= (state_nxt == ST_WSETUP) || (state_nxt == ST_WSTROBE)
                         || (state_nxt == ST_WHOLD);
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign advance = (state_q == ST_WHOLD) || (state_q == ST_RSAMPLE);
    assign capture = (state_q == ST_RSAMPLE);

    // R4: a write strobe never lasts longer than one cycle.
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        we_pulse |=> !we_pulse);

    // R4: the strobe only occurs inside an enabled chip cycle.
    a_r4_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        we_pulse |-> !ce_n);

    // R6: an accepted read keeps the output enable low for the next cycle too.
    a_r6_oe_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_rd) |=> (!oe_n && !ce_n));

endmodule

// File: rtl/loader_datapath.sv
// Data path: latches the write word and the selected half at request
// time, places the word on every half of the SRAM bus, gates the
// per-half write enables and captures the selected half on a read.
module loader_datapath #(
    parameter int WORD_W = 16,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_any,
    input  logic                    start_wr,
    input  logic [$clog2(LANES)-1:0] lane_sel,
    input  logic [WORD_W-1:0]       wdata,
    input  logic                    we_pulse,
    input  logic                    wr_active,
    input  logic                    capture,
    input  logic [LANES*WORD_W-1:0] mem_rdata,
    output logic [LANES*WORD_W-1:0] mem_wdata,
    output logic                    mem_wdata_oe,
    output logic [LANES-1:0]        we_n,
    output logic [WORD_W-1:0]       rdata,
    output logic                    rvalid
);
    localparam int LANE_W = $clog2(LANES);

    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] data_q;

    // Remember which half the current access targets.
    always_ff @(posedge clk) begin
        if (!rst_n)         lane_q <= '0;
        else if (start_any) lane_q <= lane_sel;
    end

    // Hold the write word for the whole write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (start_wr) data_q <= wdata;
    end

    // One write enable and one data copy per half.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign we_n[g] = !(we_pulse && (lane_q == LANE_W'(g)));
        assign mem_wdata[g*WORD_W +: WORD_W] = data_q;
    end

    assign mem_wdata_oe = wr_active;

    // Capture the selected half at the end of the sample cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= mem_rdata[lane_q*WORD_W +: WORD_W];
        end
    end

    // R4: at most one half is written by any strobe.
    a_r4_one_half: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~we_n) <= 1);

    // R6: read data is flagged valid for a single cycle per read.
    a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_loader_port.sv
// Top of the SRAM loader port. Decodes the register select, accepts a
// request only while idle, and ties the address counter, sequencer and
// data path together. The SRAM is two 16-bit halves wide.
module sram_loader_port
    import sram_loader_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              busy,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [31:0]       sram_wdata,
    output logic              sram_wdata_oe,
    input  logic [31:0]       sram_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_lo_n,
    output logic              sram_we_hi_n
);
    localparam int WORD_W = 16;
    localparam int LANES  = 2;

    logic       idle, is_data;
    logic       start_wr, start_rd, hi_load, lo_load;
    logic       we_pulse, wr_active, advance, capture;
    logic [1:0] we_n;

    // Request acceptance: every request is dropped while an access runs.
    assign idle     = !busy;
    assign is_data  = reg_sel[1];
    assign start_wr = idle && reg_wr && is_data;
    assign start_rd = idle && reg_rd && is_data && !reg_wr;
    assign hi_load  = idle && reg_wr && (reg_sel == SEL_ADDR_HI);
    assign lo_load  = idle && reg_wr && (reg_sel == SEL_ADDR_LO);

    loader_addr_ctr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_load (hi_load),
        .lo_load (lo_load),
        .advance (advance),
        .wdata   (reg_wdata),
        .addr    (sram_addr)
    );

    loader_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .busy      (busy),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_pulse  (we_pulse),
        .wr_active (wr_active),
        .advance   (advance),
        .capture   (capture)
    );

    loader_datapath #(.WORD_W(WORD_W), .LANES(LANES)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_any    (start_wr || start_rd),
        .start_wr     (start_wr),
        .lane_sel     (reg_sel[0]),
        .wdata        (reg_wdata),
        .we_pulse     (we_pulse),
        .wr_active    (wr_active),
        .capture      (capture),
        .mem_rdata    (sram_rdata),
        .mem_wdata    (sram_wdata),
        .mem_wdata_oe (sram_wdata_oe),
        .we_n         (we_n),
        .rdata        (reg_rdata),
        .rvalid       (reg_rvalid)
    );

    assign sram_we_lo_n = we_n[0];
    assign sram_we_hi_n = we_n[1];

    // R5: address and data hold still into the strobe cycle.
    a_r5_stable_into: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_lo_n || !sram_we_hi_n) |-> ($stable(sram_addr) && $stable(sram_wdata)));

    // R5: and for one cycle after it.
    a_r5_stable_after: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_lo_n || !sram_we_hi_n) |=> ($stable(sram_addr) && $stable(sram_wdata)));

    // R7: never read and write the SRAM at once.
    a_r7_no_oe_on_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_lo_n || !sram_we_hi_n) |-> sram_oe_n);

    // R3: the end of an access moves the address on by exactly one.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (sram_addr == $past(sram_addr) + ADDR_W'(1)));

    // R6: valid read data arrives three edges after the accepted request.
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(start_rd, 3));

    // R8: nothing starts while busy, so chip enable stays low until idle.
    a_r8_busy_ce: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sram_ce_n);

endmodule

// File: tb/sim_sram_loader_port.sv
// Scoreboard bench for the SRAM loader port with a behavioural SRAM.
module sim_sram_loader_port;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [15:0]   reg_wdata = 16'h0;
    logic [15:0]   reg_rdata;
    logic          reg_rvalid, busy;
    logic [AW-1:0] sram_addr;
    logic [31:0]   sram_wdata, sram_rdata;
    logic          sram_wdata_oe, sram_ce_n, sram_oe_n, sram_we_lo_n, sram_we_hi_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_loader_port #(.ADDR_W(AW)) u0 (.*);

    // Behavioural SRAM, indexed by the low 10 address bits.
    logic [15:0] mem_lo [0:1023];
    logic [15:0] mem_hi [0:1023];
    logic [15:0] sh_lo [0:1023];
    logic [15:0] sh_hi [0:1023];
    initial for (int i = 0; i < 1024; i++) begin
        mem_lo[i] = 16'h0; mem_hi[i] = 16'h0; sh_lo[i] = 16'h0; sh_hi[i] = 16'h0;
    end
    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_lo_n) mem_lo[sram_addr[9:0]] <= sram_wdata[15:0];
        if (!sram_ce_n && !sram_we_hi_n) mem_hi[sram_addr[9:0]] <= sram_wdata[31:16];
    end
    assign sram_rdata = (!sram_ce_n && !sram_oe_n) ?
        {mem_hi[sram_addr[9:0]], mem_lo[sram_addr[9:0]]} : 32'hDEAD_BEEF;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard queues: expected read word and request edge count.
    logic [15:0] exp_q [$];
    int          cyc_q [$];
    logic [AW-1:0] exp_addr = '0;
    int  we_run = 0;

    // Monitor: compares read results, strobe width and exclusion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rvalid) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected rvalid", 32'(reg_rdata), 0);
                else begin
                    logic [15:0] e;
                    int c;
                    e = exp_q.pop_front();
                    c = cyc_q.pop_front();
                    chk(reg_rdata == e, "R6 read data", 32'(reg_rdata), 32'(e));
                    chk(cyc - c == 3, "R6 read latency", 32'(cyc - c), 3);
                end
            end
            if (!sram_we_lo_n || !sram_we_hi_n) begin
                we_run++;
                chk(sram_oe_n, "R7 oe during we", 32'(sram_oe_n), 1);
            end else if (we_run != 0) begin
                chk(we_run == 1, "R4 strobe width", 32'(we_run), 1);
                we_run = 0;
            end
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic set_addr(input logic [AW-1:0] a);
        @(negedge clk); reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'(a >> 16);
        @(negedge clk); reg_sel = 2'd1; reg_wdata = a[15:0];
        @(negedge clk); reg_wr = 1'b0;
        exp_addr = a;
        chk(sram_addr == a, "R2 address load", 32'(sram_addr), 32'(a));
    endtask

    // Data write: half 0 = low, 1 = high. Checks the strobe cycles.
    task automatic wr_data(input bit hi, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = {1'b1, hi}; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        chk(!sram_ce_n && sram_we_lo_n && sram_we_hi_n, "R4 setup cycle",
            {29'd0, sram_ce_n, sram_we_lo_n, sram_we_hi_n}, 3'b011);
        @(negedge clk);
        chk((sram_we_hi_n == !hi) && (sram_we_lo_n == hi) && !sram_ce_n,
            "R4 strobe half", {30'd0, sram_we_hi_n, sram_we_lo_n}, {30'd0, !hi, hi});
        chk(sram_addr == exp_addr, "R5 strobe address", 32'(sram_addr), 32'(exp_addr));
        chk((hi ? sram_wdata[31:16] : sram_wdata[15:0]) == d, "R4 strobe data",
            32'(hi ? sram_wdata[31:16] : sram_wdata[15:0]), 32'(d));
        wait_idle();
        if (hi) sh_hi[exp_addr[9:0]] = d; else sh_lo[exp_addr[9:0]] = d;
        exp_addr = exp_addr + 1'b1;
        chk(sram_addr == exp_addr, "R3 advance after write", 32'(sram_addr), 32'(exp_addr));
    endtask

    // Data read: driver pushes the expected word, monitor compares.
    task automatic rd_data(input bit hi);
        @(negedge clk); reg_rd = 1'b1; reg_sel = {1'b1, hi};
        exp_q.push_back(hi ? sh_hi[exp_addr[9:0]] : sh_lo[exp_addr[9:0]]);
        cyc_q.push_back(cyc);
        @(negedge clk); reg_rd = 1'b0;
        chk(!sram_ce_n && !sram_oe_n, "R6 oe low", {30'd0, sram_ce_n, sram_oe_n}, 0);
        wait_idle();
        @(negedge clk);
        exp_addr = exp_addr + 1'b1;
        chk(sram_addr == exp_addr, "R3 advance after read", 32'(sram_addr), 32'(exp_addr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sram_ce_n && sram_oe_n && sram_we_lo_n && sram_we_hi_n && !busy && !reg_rvalid,
            "R1 reset strobes", {26'd0, sram_ce_n, sram_oe_n, sram_we_lo_n, sram_we_hi_n, busy, reg_rvalid}, 6'b111100);
        chk(sram_addr == 0, "R1 reset address", 32'(sram_addr), 0);
        @(negedge clk); rst_n = 1'b1;

        // R9: upper write alone does not move the counter
        @(negedge clk); reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0002;
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk);
        chk(sram_addr == 0, "R9 upper write alone", 32'(sram_addr), 0);

        // R2, R3, R4: burst of low-half writes then high-half writes
        set_addr(18'h2_0010);
        for (int i = 0; i < 4; i++) wr_data(1'b0, 16'h1100 + 16'(i));
        set_addr(18'h2_0010);
        for (int i = 0; i < 4; i++) wr_data(1'b1, 16'hA500 + 16'(i * 3));
        set_addr(18'h2_0010);
        for (int i = 0; i < 4; i++) rd_data(1'b0);
        set_addr(18'h2_0010);
        for (int i = 0; i < 4; i++) rd_data(1'b1);
        set_addr(18'h2_0011);
        rd_data(1'b0); rd_data(1'b1);

        // R3: wrap from all ones to zero
        set_addr(18'h3_FFFF);
        wr_data(1'b0, 16'hABCD);
        chk(sram_addr == 0, "R3 wrap to zero", 32'(sram_addr), 0);
        set_addr(18'h3_FFFF);
        rd_data(1'b0);

        // R8: requests while busy are ignored
        set_addr(18'h0_0100);
        @(negedge clk); reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 16'h5A5A;
        @(negedge clk); reg_sel = 2'd1; reg_wdata = 16'h0055;
        @(negedge clk); reg_sel = 2'd3; reg_wdata = 16'h7777;
        @(negedge clk); reg_wr = 1'b0;
        wait_idle();
        sh_lo[10'h100] = 16'h5A5A;
        exp_addr = 18'h0_0101;
        chk(sram_addr == exp_addr, "R8 address after ignored writes", 32'(sram_addr), 32'(exp_addr));
        rd_data(1'b1);
        set_addr(18'h0_0100);
        rd_data(1'b0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads returned", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule